// File: doc/BRIEF.md
# Two-Wire Register Read Target

This block is a read-only target on a two-wire serial bus of the I2C kind. It runs on a system clock and never uses the bus clock as a clock. The raw SCL and SDA levels pass through synchronisers. Bus events are detected on the synchronised copies:

- a start is SDA falling while SCL is high;
- a stop is SDA rising while SCL is high;
- bit sampling uses the rising edges of SCL;
- output launching uses the falling edges of SCL.

The target drives SDA through an enable and a data bit. The surrounding bus combines all contributions as a wired-OR. Acknowledges are therefore active-high, and a target that is not taking part contributes 0.

A transfer follows a fixed order:

1. The target takes in a 7-bit device address and a read/write flag.
2. On a match it acknowledges, then takes in a 7-bit register index.
3. It acknowledges a second time.
4. It returns the 8-bit entry stored at that index.
5. It releases the line for the master's acknowledge and the stop that follow.

The 128-entry register array is filled through a parallel preload port, which is separate from the bus.

Top module: `twire_reg_reader`

## Requirements
- R1: While reset is held and right after it is released, `sda_oe` and `sda_do` are both 0.
- R2: A frame begins only with a start (SDA falling while SCL is high) seen in the idle state. SCL pulses with data but no preceding start produce no drive on SDA.
- R3: The first frame is 8 bits, MSB first: a 7-bit address, then R/W, where 1 means read. When the address equals `DEV_ADDR` and R/W is 1, the target drives SDA to 1 for the ninth clock. The drive is enabled after the falling SCL edge that ends the eighth bit and released after the next falling edge.
- R4: On an address mismatch, `sda_oe` stays 0 for the rest of that transfer. Whenever `sda_oe` is 0, `sda_do` is 0, so the target adds 0 to the wired-OR bus.
- R5: A matching address with R/W equal to 0 (write) is not acknowledged, and the target does not drive SDA during that transfer.
- R6: After an acknowledged address, the target takes in a 7-bit register index, MSB first. It then acknowledges with a 1 in the following slot, with the same timing as R3.
- R7: After the index acknowledge, the target sends the 8-bit entry at that index, MSB first, one bit per SCL low phase. Each bit is launched after a falling SCL edge.
- R8: After the eighth data bit, the target releases SDA (`sda_oe` = 0) before the master's acknowledge slot and keeps it released until the next transfer.
- R9: `sda_oe` and `sda_do` change only in the cycle after a synchronised SCL falling edge, a start or a stop. They stay constant while SCL is high.
- R10: A start or a stop seen in the middle of a transfer aborts it. The target releases SDA and returns to idle. A start that arrives mid-transfer does not begin a new address frame.
- R11: When `pre_we` is high at a clock edge, `pre_data` is stored at entry `pre_idx`. A later write to the same entry replaces the earlier one, and entries 0 and 127 are both reachable.
- R12: The device address is the parameter `DEV_ADDR`. Any other address, including the default value when the parameter is overridden, gets no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock level from the bus |
| sda_in | input | 1 | Raw serial data level from the bus |
| pre_we | input | 1 | Preload write enable for the register array |
| pre_idx | input | IDX_W (7) | Preload entry index |
| pre_data | input | DATA_W (8) | Preload entry value |
| sda_oe | output | 1 | Enable of this target's SDA driver |
| sda_do | output | 1 | Value driven on SDA while enabled, 0 otherwise |

## Verification
The bench goes after addresses that differ from the device address only in the top or the bottom bit, a write flag on a matching address, and the default address left unmatched under an overridden parameter. A comparator that checked too few bits, or ignored the flag, would acknowledge there and then drive the bus for the rest of the frame.

Index 0 and index 127 are read back as 0xFF and as an overwritten 0x00, and an asymmetric index is read as well. These catch a reversed shift order, an off-by-one bit count, or a stale preload.

A start and a stop are injected halfway through an index. A target that did not abort, or that treated the mid-frame start as a fresh one, would acknowledge the address frame that follows. Every bit the target drives is also sampled twice while SCL is high, which exposes any launch on the rising edge.

// File: rtl/twr_pkg.sv
package twr_pkg;

  // R/W flag value that selects a read in the address frame
  localparam logic RW_READ = 1'b1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK1_WAIT,
    ST_ACK1,
    ST_INDEX,
    ST_ACK2_WAIT,
    ST_ACK2,
    ST_DATA,
    ST_PASS
  } twr_state_e;

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
      prev <= '1;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise[b] = lvl[b] & ~prev[b];
    assign fall[b] = ~lvl[b] & prev[b];
  end

endmodule

// File: rtl/twr_regfile.sv
module twr_regfile #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter int                IDX_W    = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              sda_bit,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              sda_oe,
  output logic              sda_do
);

  localparam int FRAME_W  = ADDR_W + 1;
  localparam int MAX_A    = (FRAME_W > IDX_W) ? FRAME_W : IDX_W;
  localparam int MAX_BITS = (MAX_A > DATA_W) ? MAX_A : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS);

  twr_state_e         st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] rx;
  logic [DATA_W-1:0]  tx;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] rx_next;

  function automatic logic [FRAME_W-1:0] shift_in(input logic [FRAME_W-1:0] cur, input logic b);
    return {cur[FRAME_W-2:0], b};
  endfunction

  function automatic logic frame_selects(input logic [FRAME_W-1:0] f);
    return (f[FRAME_W-1:1] == DEV_ADDR) && (f[0] == RW_READ);
  endfunction

  function automatic logic last_bit(input logic [CNT_W-1:0] c, input int width);
    return c == CNT_W'(width - 1);
  endfunction

  assign rx_next = shift_in(rx, sda_bit);
  assign rd_idx  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      rx     <= '0;
      tx     <= '0;
      idx_q  <= '0;
      sda_oe <= 1'b0;
      sda_do <= 1'b0;
    end else if (ev_start || ev_stop) begin
      sda_oe <= 1'b0;
      sda_do <= 1'b0;
      cnt    <= '0;
      rx     <= '0;
      st     <= (ev_start && st == ST_IDLE) ? ST_ADDR : ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR: if (scl_rise) begin
          rx  <= rx_next;
          cnt <= cnt + 1'b1;
          if (last_bit(cnt, FRAME_W)) begin
            cnt <= '0;
            st  <= frame_selects(rx_next) ? ST_ACK1_WAIT : ST_PASS;
          end
        end
        ST_ACK1_WAIT: if (scl_fall) begin
          sda_oe <= 1'b1;
          sda_do <= 1'b1;
          st     <= ST_ACK1;
        end
        ST_ACK1: if (scl_fall) begin
          sda_oe <= 1'b0;
          sda_do <= 1'b0;
          rx     <= '0;
          st     <= ST_INDEX;
        end
        ST_INDEX: if (scl_rise) begin
          rx  <= rx_next;
          cnt <= cnt + 1'b1;
          if (last_bit(cnt, IDX_W)) begin
            cnt   <= '0;
            idx_q <= rx_next[IDX_W-1:0];
            st    <= ST_ACK2_WAIT;
          end
        end
        ST_ACK2_WAIT: if (scl_fall) begin
          sda_oe <= 1'b1;
          sda_do <= 1'b1;
          st     <= ST_ACK2;
        end
        ST_ACK2: if (scl_fall) begin
          tx     <= rd_data << 1;
          sda_oe <= 1'b1;
          sda_do <= rd_data[DATA_W-1];
          cnt    <= '0;
          st     <= ST_DATA;
        end
        ST_DATA: if (scl_fall) begin
          if (last_bit(cnt, DATA_W)) begin
            sda_oe <= 1'b0;
            sda_do <= 1'b0;
            st     <= ST_PASS;
          end else begin
            sda_do <= tx[DATA_W-1];
            tx     <= tx << 1;
            cnt    <= cnt + 1'b1;
          end
        end
        ST_PASS: ;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twire_reg_reader.sv
module twire_reg_reader #(
  parameter int                ADDR_W      = 7,
  parameter int                IDX_W       = 7,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              pre_we,
  input  logic [IDX_W-1:0]  pre_idx,
  input  logic [DATA_W-1:0] pre_data,
  output logic              sda_oe,
  output logic              sda_do
);

  localparam int L_SCL = 0;
  localparam int L_SDA = 1;

  logic [1:0] lvl, rise, fall;

  // named bus events, also observed by the bound checker
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, ev_start, ev_stop;

  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;

  twr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({sda_in, scl_in}),
    .lvl   (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  assign scl_lvl  = lvl[L_SCL];
  assign scl_rise = rise[L_SCL];
  assign scl_fall = fall[L_SCL];
  assign sda_lvl  = lvl[L_SDA];
  assign ev_start = fall[L_SDA] & scl_lvl & ~scl_rise;
  assign ev_stop  = rise[L_SDA] & scl_lvl & ~scl_rise;

  twr_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .we      (pre_we),
    .wr_idx  (pre_idx),
    .wr_data (pre_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  twr_ctrl #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .sda_bit  (sda_lvl),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .sda_oe   (sda_oe),
    .sda_do   (sda_do)
  );

endmodule

// File: rtl/twr_chk.sv
module twr_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic sda_do,
  input logic scl_lvl,
  input logic scl_fall,
  input logic ev_start,
  input logic ev_stop
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  // R4
  zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe |-> !sda_do);

  // R9
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sda_oe, sda_do}) |-> $past(scl_fall || ev_start || ev_stop));

  // R9
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(ev_start || ev_stop)) |-> $stable(sda_oe));

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> !sda_oe);

endmodule

bind twire_reg_reader twr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .sda_do   (sda_do),
  .scl_lvl  (scl_lvl),
  .scl_fall (scl_fall),
  .ev_start (ev_start),
  .ev_stop  (ev_stop)
);

// File: tb/sim_twire_reg_reader.sv
`timescale 1ns/1ps
module sim_twire_reg_reader;

  localparam logic [6:0] DEV = 7'h2A;
  localparam int H  = 10;
  localparam int NV = 9;
  // {address, r/w, index, expected address acknowledge}
  localparam logic [15:0] VEC [NV] = '{
    {7'h2A, 1'b1, 7'h00, 1'b1},
    {7'h2A, 1'b1, 7'h7F, 1'b1},
    {7'h2A, 1'b1, 7'h15, 1'b1},
    {7'h2A, 1'b1, 7'h54, 1'b1},
    {7'h2B, 1'b1, 7'h10, 1'b0},
    {7'h6A, 1'b1, 7'h10, 1'b0},
    {7'h2A, 1'b0, 7'h10, 1'b0},
    {7'h50, 1'b1, 7'h10, 1'b0},
    {7'h2A, 1'b1, 7'h40, 1'b1}
  };

  logic clk = 0;
  logic rst_n;
  logic scl, m_en, m_bit;
  logic pre_we;
  logic [6:0] pre_idx;
  logic [7:0] pre_data;
  logic sda_oe, sda_do;
  wire  sda_bus = (m_en & m_bit) | (sda_oe & sda_do);

  int n_chk = 0;
  int n_bad = 0;
  int oe_cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (sda_oe) oe_cycles++;

  twire_reg_reader #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .pre_we(pre_we), .pre_idx(pre_idx), .pre_data(pre_data),
    .sda_oe(sda_oe), .sda_do(sda_do)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 90) ^ (i * 4));
  endfunction

  function automatic logic [7:0] exp_mem(input int i);
    if (i == 0)   return 8'hFF;
    if (i == 127) return 8'h00;
    return pat(i);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic preload(input int i, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1; pre_idx = 7'(i); pre_data = d;
    @(negedge clk);
    pre_we = 0;
  endtask

  task automatic do_start();
    m_en = 1; m_bit = 1; scl = 1; half();
    m_bit = 0; half();
    scl = 0; half();
  endtask

  task automatic do_stop();
    repeat (2) @(negedge clk);
    m_en = 1; m_bit = 0; half();
    scl = 1; half();
    m_bit = 1; half();
  endtask

  task automatic send_bit(input logic b);
    repeat (2) @(negedge clk);
    m_en = 1; m_bit = b; half();
    scl = 1; half();
    scl = 0;
  endtask

  task automatic recv_bit(output logic r);
    logic r1, r2;
    repeat (2) @(negedge clk);
    m_en = 0; half();
    scl = 1;
    repeat (H / 2) @(negedge clk);
    r1 = sda_bus;
    repeat (H - H / 2) @(negedge clk);
    r2 = sda_bus;
    chk(r1 == r2, "R9 hold while SCL high", r2, r1);
    scl = 0;
    r = r1;
  endtask

  task automatic send_addr(input logic [6:0] ad, input logic rw);
    for (int i = 6; i >= 0; i--) send_bit(ad[i]);
    send_bit(rw);
  endtask

  task automatic run_read(input logic [6:0] ad, input logic rw, input logic [6:0] ix,
                          output logic a1, output logic a2, output logic [7:0] dat,
                          output logic rel, output int oed);
    int oe0;
    logic b;
    oe0 = oe_cycles;
    do_start();
    send_addr(ad, rw);
    recv_bit(a1);
    for (int i = 6; i >= 0; i--) send_bit(ix[i]);
    recv_bit(a2);
    dat = '0;
    for (int i = 0; i < 8; i++) begin
      recv_bit(b);
      dat = {dat[6:0], b};
    end
    // master acknowledge slot
    repeat (2) @(negedge clk);
    m_en = 1; m_bit = 1; half();
    scl = 1;
    repeat (H / 2) @(negedge clk);
    rel = !sda_oe;
    repeat (H - H / 2) @(negedge clk);
    scl = 0;
    do_stop();
    oed = oe_cycles - oe0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a1, a2, rel, ea, b;
    logic [7:0] dat;
    int oed, oe0;
    string tg;

    rst_n = 0; scl = 1; m_en = 1; m_bit = 1;
    pre_we = 0; pre_idx = '0; pre_data = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk({sda_oe, sda_do} == 2'b00, "R1 in reset", {sda_oe, sda_do}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({sda_oe, sda_do} == 2'b00, "R1 after release", {sda_oe, sda_do}, 0);

    // R11: fill the array, then overwrite the edge entries
    for (int i = 0; i < 128; i++) preload(i, pat(i));
    preload(0, 8'hFF);
    preload(127, 8'h3C);
    preload(127, 8'h00);

    for (int v = 0; v < NV; v++) begin
      ea = VEC[v][0];
      run_read(VEC[v][15:9], VEC[v][8], VEC[v][7:1], a1, a2, dat, rel, oed);
      if (ea) tg = "R3";
      else if (!VEC[v][8]) tg = "R5";
      else if (VEC[v][15:9] == 7'h50) tg = "R12";
      else tg = "R4";
      chk(a1 == ea, {tg, " address ack"}, a1, ea);
      if (ea) begin
        chk(a2 == 1'b1, "R6 index ack", a2, 1);
        chk(dat == exp_mem(int'(VEC[v][7:1])), "R7 R11 data byte", dat, exp_mem(int'(VEC[v][7:1])));
        chk(rel, "R8 released in master ack slot", !rel, 0);
      end else begin
        chk(oed == 0, {tg, " no drive"}, oed, 0);
        chk(dat == 8'h00, {tg, " bus quiet"}, dat, 0);
      end
    end

    // R10: start inside the index frame aborts, next frame is not served
    do_start();
    send_addr(DEV, 1'b1);
    recv_bit(a1);
    chk(a1 == 1'b1, "R3 ack before abort", a1, 1);
    send_bit(1'b0);
    send_bit(1'b1);
    repeat (2) @(negedge clk);
    m_en = 1; m_bit = 1; half();
    scl = 1; half();
    m_bit = 0; half();
    scl = 0;
    oe0 = oe_cycles;
    send_addr(DEV, 1'b1);
    recv_bit(a1);
    chk(a1 == 1'b0, "R10 no ack after mid-frame start", a1, 0);
    chk(oe_cycles == oe0, "R10 released after start abort", oe_cycles - oe0, 0);
    do_stop();

    // R10: stop inside the index frame aborts; R2: bits without a start ignored
    do_start();
    send_addr(DEV, 1'b1);
    recv_bit(a1);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    do_stop();
    oe0 = oe_cycles;
    scl = 0; half();
    send_addr(DEV, 1'b1);
    recv_bit(b);
    chk(b == 1'b0, "R2 no ack without start", b, 0);
    chk(oe_cycles == oe0, "R2 R10 no drive after stop abort", oe_cycles - oe0, 0);
    do_stop();

    // R10: service resumes after the aborts
    run_read(DEV, 1'b1, 7'h33, a1, a2, dat, rel, oed);
    chk(a1 && a2, "R10 recovery acks", {a1, a2}, 3);
    chk(dat == exp_mem(8'h33), "R10 recovery data", dat, exp_mem(8'h33));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule